// File: doc/BRIEF.md
# Converter Output Test Pattern Generator

This block sits on the output path of a 10-bit sampling converter. In normal operation it passes each live sample word through to its output. When a non-zero pattern code is selected, it replaces the live word with a word from a built-in source and raises a flag that marks the output as test data. One word is produced per sample clock, and the output is registered once.

The sources are fixed levels, alternating words, two pseudo-random generators with separate reseed controls, two user-programmed words, a one-time sync marker, a walking one and a mixed-frequency ramp. A small sequencer sets the phase of every alternating or one-shot source. It has three states. `SEQ_A` emits the first word. `SEQ_B` emits the second word. `SEQ_DONE` emits zero and stays there. The transitions are as follows. A restart (any change of pattern code or user mode) forces the current cycle to `SEQ_A`. `SEQ_A` moves to `SEQ_DONE` when the source stops after one word (sync marker, user single-once) and to `SEQ_B` otherwise. `SEQ_B` moves to `SEQ_DONE` when the source stops after two words (user alternate-once) and back to `SEQ_A` otherwise. `SEQ_DONE` holds until the next restart.

Top module: `adc_test_pattern_gen`

## Requirements
- R1: With pattern code 0 or any unused code (13, 14, 15), `data_out` equals the `sample_in` value from the previous clock, and `test_active` is low.
- R2: For codes 1 to 12, `test_active` is high one clock after the code is presented.
- R3: Code 1 gives 0x200, code 2 gives 0x3FF and code 3 gives 0x000, steadily.
- R4: Three codes alternate between two words, starting with the first word on the cycle after a restart. Code 4 alternates 0x155 and 0x2AA. Code 7 alternates 0x3FF and 0x000. Code 9 alternates 0x333 and 0x0CC.
- R5: Code 6 outputs the short generator (x^9+x^5+1). Each clock takes 10 shift steps, and each step's new bit is state[8]^state[4], shifted in at bit 0. The first new bit lands in output bit 9.
- R6: Code 5 outputs the long generator (x^23+x^18+1), built in the same way with new bit state[22]^state[17].
- R7: Each generator runs every clock whether or not it is selected. Both seed to all ones on reset. `pn_short_rst` reseeds only the short generator and `pn_long_rst` reseeds only the long one. In a reseed cycle the output word still comes from the old state.
- R8: Code 8 outputs the user pattern bits [15:6]. With `user_mode` 00 it repeats pattern 1. With mode 01 it alternates pattern 1 and pattern 2, starting with pattern 1.
- R9: With code 8 and `user_mode` 10, pattern 1 is sent once and the output then holds at 0. With mode 11, pattern 1 and then pattern 2 are sent once and the output then holds at 0.
- R10: Code 10 outputs 0x3FF for one cycle after a restart and then holds at 0x000.
- R11: Code 11 outputs a single high bit that starts at bit 0 and moves up one position per clock, wrapping from bit 9 back to bit 0.
- R12: Code 12 outputs a counter that starts at 0 after a restart and increments by one per clock, so bit i toggles every 2^i clocks.
- R13: A change of pattern code or user mode takes effect on the next clock and restarts every sequenced source at its first word.
- R14: While `rst_n` is low, `data_out` is 0 and `test_active` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_in | input | 10 | Live converter word |
| pat_sel | input | 4 | Pattern code |
| user_mode | input | 2 | User pattern playback mode |
| user_pat1 | input | 16 | User pattern 1 (MSB byte and LSB byte) |
| user_pat2 | input | 16 | User pattern 2 (MSB byte and LSB byte) |
| pn_long_rst | input | 1 | Reseed the long generator |
| pn_short_rst | input | 1 | Reseed the short generator |
| data_out | output | 10 | Registered output word |
| test_active | output | 1 | High while the output carries test data |

## Verification
A wrong sequencer state appears at once as the wrong one of the two words, or as a missing zero after a one-shot sequence, on the very next output word. A corrupted generator state or a wrong tap shows as a differing word on the first cycle the generator is selected. Because the generators run freely, a wrong reseed or an extra advance stays visible in every later word. The bench model tracks these states independently and compares every cycle. A lost restart shows within one word as a sequence that resumes mid-phase instead of starting at its first word.

// File: rtl/adc_tpg_pkg.sv
package adc_tpg_pkg;

    typedef enum logic [3:0] {
        PAT_OFF         = 4'd0,
        PAT_MID         = 4'd1,
        PAT_POS_FS      = 4'd2,
        PAT_NEG_FS      = 4'd3,
        PAT_CHECKER     = 4'd4,
        PAT_PN_LONG     = 4'd5,
        PAT_PN_SHORT    = 4'd6,
        PAT_WORD_TOGGLE = 4'd7,
        PAT_USER        = 4'd8,
        PAT_PAIR_TOGGLE = 4'd9,
        PAT_SYNC_ONCE   = 4'd10,
        PAT_WALK_ONE    = 4'd11,
        PAT_MIXED_FREQ  = 4'd12
    } tpg_pattern_e;

    typedef enum logic [1:0] {
        UM_REPEAT      = 2'd0,
        UM_ALT         = 2'd1,
        UM_SINGLE_ONCE = 2'd2,
        UM_ALT_ONCE    = 2'd3
    } tpg_user_mode_e;

    typedef enum logic [1:0] {
        SEQ_A    = 2'd0,
        SEQ_B    = 2'd1,
        SEQ_DONE = 2'd2
    } seq_state_t;

endpackage

// File: rtl/adc_tpg_pn.sv
module adc_tpg_pn #(
    parameter int LEN   = 9,
    parameter int TAP   = 5,
    parameter int OUT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reseed,
    output logic [OUT_W-1:0] word
);

    logic [LEN-1:0] state_q;
    logic [LEN-1:0] state_nxt;

    // OUT_W serial steps per clock; first produced bit lands in the MSB
    always_comb begin
        logic [LEN-1:0] s;
        logic           nb;
        s    = state_q;
        word = '0;
        for (int i = 0; i < OUT_W; i++) begin
            nb = s[LEN-1] ^ s[TAP-1];
            word[OUT_W-1-i] = nb;
            s = {s[LEN-2:0], nb};
        end
        state_nxt = s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '1;
        end else if (reseed) begin
            state_q <= '1;
        end else begin
            state_q <= state_nxt;
        end
    end

    AST_PN_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0); // R5

endmodule

// File: rtl/adc_tpg_seq.sv
module adc_tpg_seq
    import adc_tpg_pkg::*;
#(
    parameter int OUT_W  = 10,
    parameter int WALK_W = $clog2(OUT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              stop_after_a,
    input  logic              stop_after_b,
    output seq_state_t        eff_state,
    output logic [OUT_W-1:0]  ramp,
    output logic [WALK_W-1:0] walk_idx
);

    localparam logic [WALK_W-1:0] WALK_LAST = WALK_W'(OUT_W - 1);

    seq_state_t        state_q, state_nxt;
    logic [OUT_W-1:0]  ramp_q;
    logic [WALK_W-1:0] walk_q;

    assign eff_state = restart ? SEQ_A : state_q;
    assign ramp      = restart ? '0 : ramp_q;
    assign walk_idx  = restart ? '0 : walk_q;

    always_comb begin
        state_nxt = eff_state;
        unique case (eff_state)
            SEQ_A:    state_nxt = stop_after_a ? SEQ_DONE : SEQ_B;
            SEQ_B:    state_nxt = stop_after_b ? SEQ_DONE : SEQ_A;
            SEQ_DONE: state_nxt = SEQ_DONE;
            default:  state_nxt = SEQ_A;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_A;
            ramp_q  <= '0;
            walk_q  <= '0;
        end else begin
            state_q <= state_nxt;
            ramp_q  <= ramp + 1'b1;
            walk_q  <= (walk_idx == WALK_LAST) ? '0 : walk_idx + 1'b1;
        end
    end

    AST_RESTART_LEAVES_A: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (state_q != SEQ_A)); // R13

endmodule

// File: rtl/adc_test_pattern_gen.sv
module adc_test_pattern_gen
    import adc_tpg_pkg::*;
#(
    parameter int OUT_W     = 10,
    parameter int PAT_W     = 16,
    parameter int SHORT_LEN = 9,
    parameter int SHORT_TAP = 5,
    parameter int LONG_LEN  = 23,
    parameter int LONG_TAP  = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OUT_W-1:0] sample_in,
    input  logic [3:0]       pat_sel,
    input  logic [1:0]       user_mode,
    input  logic [PAT_W-1:0] user_pat1,
    input  logic [PAT_W-1:0] user_pat2,
    input  logic             pn_long_rst,
    input  logic             pn_short_rst,
    output logic [OUT_W-1:0] data_out,
    output logic             test_active
);

    localparam int WALK_W = $clog2(OUT_W);
    localparam logic [OUT_W-1:0] MID_WORD  = OUT_W'(1) << (OUT_W - 1);
    localparam logic [OUT_W-1:0] CHECK_A   = {(OUT_W/2){2'b01}};
    localparam logic [OUT_W-1:0] PAIR_A    = pair_word();

    function automatic logic [OUT_W-1:0] pair_word();
        logic [OUT_W-1:0] w;
        for (int i = 0; i < OUT_W; i++) w[i] = ((i / 2) % 2) == 0;
        return w;
    endfunction

    logic [3:0]        prev_sel_q;
    logic [1:0]        prev_mode_q;
    logic              restart;
    logic              stop_after_a, stop_after_b;
    logic [OUT_W-1:0]  pn_short_word, pn_long_word;
    seq_state_t        seq_st;
    logic [OUT_W-1:0]  ramp;
    logic [WALK_W-1:0] walk_idx;
    logic [OUT_W-1:0]  usr1, usr2;
    logic [OUT_W-1:0]  nxt_data;
    logic              nxt_active;

    assign restart      = (pat_sel != prev_sel_q) || (user_mode != prev_mode_q);
    assign stop_after_a = (pat_sel == PAT_SYNC_ONCE) ||
                          ((pat_sel == PAT_USER) && (user_mode == UM_SINGLE_ONCE));
    assign stop_after_b = (pat_sel == PAT_USER) && (user_mode == UM_ALT_ONCE);
    assign usr1         = user_pat1[PAT_W-1 -: OUT_W];
    assign usr2         = user_pat2[PAT_W-1 -: OUT_W];

    adc_tpg_pn #(.LEN(SHORT_LEN), .TAP(SHORT_TAP), .OUT_W(OUT_W)) u_pn_short (
        .clk    (clk),
        .rst_n  (rst_n),
        .reseed (pn_short_rst),
        .word   (pn_short_word)
    );

    adc_tpg_pn #(.LEN(LONG_LEN), .TAP(LONG_TAP), .OUT_W(OUT_W)) u_pn_long (
        .clk    (clk),
        .rst_n  (rst_n),
        .reseed (pn_long_rst),
        .word   (pn_long_word)
    );

    adc_tpg_seq #(.OUT_W(OUT_W), .WALK_W(WALK_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart      (restart),
        .stop_after_a (stop_after_a),
        .stop_after_b (stop_after_b),
        .eff_state    (seq_st),
        .ramp         (ramp),
        .walk_idx     (walk_idx)
    );

    always_comb begin
        nxt_data   = sample_in;
        nxt_active = 1'b1;
        unique case (pat_sel)
            PAT_MID:         nxt_data = MID_WORD;
            PAT_POS_FS:      nxt_data = '1;
            PAT_NEG_FS:      nxt_data = '0;
            PAT_CHECKER:     nxt_data = (seq_st == SEQ_A) ? CHECK_A : ~CHECK_A;
            PAT_PN_LONG:     nxt_data = pn_long_word;
            PAT_PN_SHORT:    nxt_data = pn_short_word;
            PAT_WORD_TOGGLE: nxt_data = (seq_st == SEQ_A) ? '1 : '0;
            PAT_USER: begin
                unique case (user_mode)
                    UM_REPEAT:      nxt_data = usr1;
                    UM_ALT:         nxt_data = (seq_st == SEQ_A) ? usr1 : usr2;
                    UM_SINGLE_ONCE: nxt_data = (seq_st == SEQ_A) ? usr1 : '0;
                    default:        nxt_data = (seq_st == SEQ_A) ? usr1 :
                                               (seq_st == SEQ_B) ? usr2 : '0;
                endcase
            end
            PAT_PAIR_TOGGLE: nxt_data = (seq_st == SEQ_A) ? PAIR_A : ~PAIR_A;
            PAT_SYNC_ONCE:   nxt_data = (seq_st == SEQ_A) ? '1 : '0;
            PAT_WALK_ONE:    nxt_data = OUT_W'(1) << walk_idx;
            PAT_MIXED_FREQ:  nxt_data = ramp;
            default: begin
                nxt_data   = sample_in;
                nxt_active = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_sel_q  <= '0;
            prev_mode_q <= '0;
            data_out    <= '0;
            test_active <= 1'b0;
        end else begin
            prev_sel_q  <= pat_sel;
            prev_mode_q <= user_mode;
            data_out    <= nxt_data;
            test_active <= nxt_active;
        end
    end

    AST_OFF_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_sel == 4'd0) |=> ((data_out == $past(sample_in)) && !test_active)); // R1

    AST_FLAG_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pat_sel >= 4'd1) && (pat_sel <= 4'd12)) |=> test_active); // R2

    AST_WALK_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_sel == 4'd11) |=> ($countones(data_out) == 1)); // R11

endmodule

// File: tb/adc_test_pattern_gen_tb_top.sv
module adc_test_pattern_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  sample_in = '0;
    logic [3:0]  pat_sel = '0;
    logic [1:0]  user_mode = '0;
    logic [15:0] user_pat1 = 16'hABCD;
    logic [15:0] user_pat2 = 16'h1357;
    logic        pn_long_rst = 1'b0;
    logic        pn_short_rst = 1'b0;
    logic [9:0]  data_out;
    logic        test_active;

    always #4 clk = ~clk;

    adc_test_pattern_gen dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_in    (sample_in),
        .pat_sel      (pat_sel),
        .user_mode    (user_mode),
        .user_pat1    (user_pat1),
        .user_pat2    (user_pat2),
        .pn_long_rst  (pn_long_rst),
        .pn_short_rst (pn_short_rst),
        .data_out     (data_out),
        .test_active  (test_active)
    );

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;
    int unsigned lcg = 32'h1234_5678;

    // reference model state
    int          m_psel, m_pmode, m_st, m_cnt, m_walk;
    logic [8:0]  m_pn9;
    logic [22:0] m_pn23;
    logic [9:0]  e_out;
    bit          e_act;
    string       e_req;

    function automatic logic [9:0] pn9_word(input logic [8:0] s, output logic [8:0] nxt);
        logic [9:0] w;
        logic nb;
        for (int i = 0; i < 10; i++) begin
            nb = s[8] ^ s[4];
            w[9-i] = nb;
            s = {s[7:0], nb};
        end
        nxt = s;
        return w;
    endfunction

    function automatic logic [9:0] pn23_word(input logic [22:0] s, output logic [22:0] nxt);
        logic [9:0] w;
        logic nb;
        for (int i = 0; i < 10; i++) begin
            nb = s[22] ^ s[17];
            w[9-i] = nb;
            s = {s[21:0], nb};
        end
        nxt = s;
        return w;
    endfunction

    task automatic model_reset();
        m_psel = 0; m_pmode = 0; m_st = 0; m_cnt = 0; m_walk = 0;
        m_pn9 = '1; m_pn23 = '1;
        e_out = '0; e_act = 0; e_req = "R14";
    endtask

    task automatic model_step(input string req);
        bit restart;
        int st, cnt, walk, sel, mode, nst;
        logic [9:0] w9, w23, u1, u2;
        logic [8:0] n9;
        logic [22:0] n23;
        sel = int'(pat_sel); mode = int'(user_mode);
        restart = (sel != m_psel) || (mode != m_pmode);
        st   = restart ? 0 : m_st;
        cnt  = restart ? 0 : m_cnt;
        walk = restart ? 0 : m_walk;
        w9  = pn9_word(m_pn9, n9);
        w23 = pn23_word(m_pn23, n23);
        u1 = user_pat1[15:6];
        u2 = user_pat2[15:6];
        e_act = (sel >= 1 && sel <= 12);
        case (sel)
            1:  e_out = 10'h200;
            2:  e_out = 10'h3FF;
            3:  e_out = 10'h000;
            4:  e_out = (st == 0) ? 10'h155 : 10'h2AA;
            5:  e_out = w23;
            6:  e_out = w9;
            7:  e_out = (st == 0) ? 10'h3FF : 10'h000;
            8: begin
                if (mode == 0)      e_out = u1;
                else if (mode == 1) e_out = (st == 0) ? u1 : u2;
                else if (mode == 2) e_out = (st == 0) ? u1 : 10'h0;
                else                e_out = (st == 0) ? u1 : (st == 1) ? u2 : 10'h0;
            end
            9:  e_out = (st == 0) ? 10'h333 : 10'h0CC;
            10: e_out = (st == 0) ? 10'h3FF : 10'h000;
            11: e_out = 10'(1 << walk);
            12: e_out = 10'(cnt);
            default: e_out = sample_in;
        endcase
        if (st == 0)
            nst = ((sel == 10) || (sel == 8 && mode == 2)) ? 2 : 1;
        else if (st == 1)
            nst = (sel == 8 && mode == 3) ? 2 : 0;
        else
            nst = 2;
        m_psel = sel; m_pmode = mode; m_st = nst;
        m_cnt  = (cnt + 1) % 1024;
        m_walk = (walk == 9) ? 0 : walk + 1;
        m_pn9  = pn_short_rst ? 9'h1FF : n9;
        m_pn23 = pn_long_rst ? 23'h7FFFFF : n23;
        e_req  = req;
    endtask

    task automatic compare();
        compared++;
        if (data_out !== e_out || test_active !== e_act) begin
            mismatched++;
            $display("FAIL %s: data_out=%h test_active=%0b expected data_out=%h test_active=%0b",
                     e_req, data_out, test_active, e_out, e_act);
        end
    endtask

    task automatic cycle(input int sel, input int mode, input bit r_short, input bit r_long,
                         input string req);
        @(negedge clk);
        compare();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        sample_in    = lcg[25:16];
        pat_sel      = 4'(sel);
        user_mode    = 2'(mode);
        pn_short_rst = r_short;
        pn_long_rst  = r_long;
        if (rst_n) model_step(req);
        else       model_reset();
    endtask

    task automatic run(input int n, input int sel, input int mode, input string req);
        for (int i = 0; i < n; i++) cycle(sel, mode, 0, 0, req);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        model_reset();
        rst_n = 1'b0;
        run(3, 5, 0, "R14");                  // R14: reset holds outputs low
        @(negedge clk);
        compare();
        rst_n = 1'b1;
        pat_sel = '0;
        model_step("R1");
        run(20, 0, 0, "R1");                  // R1: live passthrough
        run(6, 13, 0, "R1");                  // R1: unused codes
        run(6, 14, 0, "R1");
        run(6, 15, 0, "R1");
        for (int c = 1; c <= 12; c++) run(1, c, 0, "R2"); // R2: flag per code
        run(4, 1, 0, "R3");                   // R3: fixed levels
        run(4, 2, 0, "R3");
        run(4, 3, 0, "R3");
        run(6, 4, 0, "R4");                   // R4: alternating words
        run(6, 7, 0, "R4");
        run(6, 9, 0, "R4");
        run(30, 6, 0, "R5");                  // R5: short generator
        run(30, 5, 0, "R6");                  // R6: long generator
        cycle(6, 0, 1, 0, "R7");              // R7: short reseed
        run(8, 6, 0, "R7");
        cycle(6, 0, 0, 1, "R7");              // R7: long reseed leaves short alone
        run(8, 6, 0, "R7");
        cycle(5, 0, 0, 1, "R7");
        run(8, 5, 0, "R7");
        cycle(5, 0, 1, 0, "R7");
        run(8, 5, 0, "R7");
        run(6, 8, 0, "R8");                   // R8: repeat
        run(7, 8, 1, "R8");                   // R8: alternate
        run(5, 8, 2, "R9");                   // R9: single once
        run(6, 8, 3, "R9");                   // R9: alternate once
        run(5, 10, 0, "R10");                 // R10: sync once
        run(25, 11, 0, "R11");                // R11: walking one
        run(40, 12, 0, "R12");                // R12: ramp
        run(3, 8, 3, "R13");                  // R13: restart on mode change
        run(1, 8, 2, "R13");
        run(3, 8, 3, "R13");
        run(2, 10, 0, "R13");                 // R13: restart on code change
        run(2, 12, 0, "R13");
        run(3, 10, 0, "R13");
        run(3, 4, 0, "R13");
        run(3, 9, 0, "R13");
        run(5, 11, 0, "R13");
        run(2, 12, 0, "R13");
        @(negedge clk);
        compare();
        rst_n = 1'b0;                         // R14: reset in mid-run
        model_reset();
        run(3, 6, 0, "R14");
        @(negedge clk);
        compare();
        rst_n = 1'b1;
        pat_sel = 4'd6;
        model_step("R7");
        run(10, 6, 0, "R7");                  // R7: seeds restored after reset
        @(negedge clk);
        compare();
        finish_run();
    end

endmodule